// File: doc/BRIEF.md
# I2C Bus-Clear Pulse Generator

This block frees an I2C bus whose data line is held low by a target device that stopped in the middle of a byte. When software starts it, the block toggles the clock line for a set number of pulses and watches the data line between pulses. When the data line is seen released, it stops early. It can optionally finish with a STOP condition. At the end it sets a sticky interrupt flag that software clears by writing a one to it.

Settings are written into a staging register. They reach the working copy only through a load handshake. That handshake completes on the next pulse-rate tick, which arrives from an external divider. A single status bit tells software whether the bus came free. The block only drives the lines low, so the pad logic treats each drive output as an open-drain pull-down.

Top module: `i2c_bus_recover`

## Requirements
- R1: After synchronous reset, both drive outputs are 0. `busy_o`, `load_pending_o`, `irq_done_o`, `sda_freed_o` and `cfg_q_o` are also 0.
- R2: The configuration word uses these fields: bit 0 is the enable, bit 1 is the STOP request, and bits 23:16 are the pulse threshold.
  - A write to the staging register (`cfg_wr`) changes nothing on its own.
  - `load_req` sets `load_pending_o`.
  - On the next clock edge with `tick` high, the staged value is copied into `cfg_q_o`, with unused bits reading 0, and `load_pending_o` clears.
  - If the staged enable bit is 1, the sequence starts at that same edge.
- R3: Each pulse holds `scl_low_o` at 1 for exactly one tick period, then at 0 for one tick period. The data line is sampled at the tick that ends the released phase.
- R4: The sequence ends after the number of pulses given by the threshold. A threshold of 0 is treated as 1.
- R5: The sequence ends right after the first pulse whose sample finds `sda_in` high.
- R6: If STOP was requested, then after the last pulse the block does three things in order:
  - drives `sda_low_o` together with `scl_low_o` for one tick period;
  - drives `sda_low_o` alone for one tick period;
  - releases both lines.
  Without the request, `sda_low_o` stays 0.
- R7: When a sequence ends, `irq_done_o` (interrupt status bit 11) is set.
  - It stays set until an `int_wr` with `int_wdata` bit 11 equal to 1 clears it.
  - A write with bit 11 equal to 0 leaves it set.
  - Setting wins over a clear in the same cycle.
- R8: At completion, `sda_freed_o` is set to 1 if the last sample found the data line high, and 0 otherwise.
- R9: The enable bit in `cfg_q_o` clears itself when the sequence completes. A load carrying enable while a sequence runs neither restarts it nor changes its pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse-rate strobe from the external divider |
| cfg_wr | input | 1 | Write strobe for the staging configuration register |
| cfg_wdata | input | 32 | Configuration word (enable bit 0, STOP bit 1, threshold 23:16) |
| load_req | input | 1 | Request to copy the staged configuration into the working copy |
| int_wr | input | 1 | Write strobe for the interrupt status register |
| int_wdata | input | 32 | Write-one-to-clear data; bit 11 clears the done flag |
| sda_in | input | 1 | Sensed level of the data line |
| scl_low_o | output | 1 | 1 pulls the clock line low |
| sda_low_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | A sequence is in progress |
| load_pending_o | output | 1 | A configuration load is waiting for the next tick |
| cfg_q_o | output | 32 | Working configuration readback |
| irq_done_o | output | 1 | Sticky done flag (interrupt status bit 11) |
| sda_freed_o | output | 1 | Status bit 0: the data line was released at the end |

## Verification
The assertions assume four things about the inputs:
- `tick` is a single-cycle strobe, so every phase lasts a whole number of tick periods.
- `sda_in` only changes away from the sampling tick.
- Software does not clear the done flag in the cycle it is set.
- `sda_in` is the wired level of the line, so it reads low while the block itself pulls the data line.

The bench stays within these assumptions. It builds `tick` as one cycle in every four. It models the stuck target as a counter of clock-line releases that changes the data level only after a release edge, several cycles before the next sample. It combines that level with `sda_low_o`, and it issues clears only after the flag is seen set.

// File: rtl/bc_pkg.sv
package bc_pkg;

    localparam int WORD_W   = 32;
    localparam int THR_W    = 8;
    localparam int EN_POS   = 0;
    localparam int STOP_POS = 1;
    localparam int THR_LSB  = 16;
    localparam int IRQ_POS  = 11;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             stop;
        logic             en;
    } bc_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STOP_A,
        ST_STOP_B,
        ST_END
    } bc_state_t;

    function automatic bc_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        bc_cfg_t c;
        c.en   = w[EN_POS];
        c.stop = w[STOP_POS];
        c.thr  = w[THR_LSB +: THR_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(input bc_cfg_t c);
        logic [WORD_W-1:0] w;
        w                    = '0;
        w[EN_POS]            = c.en;
        w[STOP_POS]          = c.stop;
        w[THR_LSB +: THR_W]  = c.thr;
        return w;
    endfunction

    function automatic logic [THR_W-1:0] pulse_limit(input logic [THR_W-1:0] t);
        return (t == '0) ? {{(THR_W-1){1'b0}}, 1'b1} : t;
    endfunction

endpackage

// File: rtl/bc_shadow.sv
module bc_shadow
    import bc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              load_req,
    input  logic              busy,
    input  logic              seq_done,
    output bc_cfg_t           staged,
    output bc_cfg_t           active,
    output logic              pending,
    output logic              start
);

    bc_cfg_t staged_q;
    bc_cfg_t active_q;
    logic    pend_q;
    logic    apply;

    assign apply   = pend_q & tick;
    assign start   = apply & staged_q.en & ~busy;
    assign staged  = staged_q;
    assign active  = active_q;
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            active_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (cfg_wr) begin
                staged_q <= cfg_unpack(cfg_wdata);
            end
            pend_q <= load_req | (pend_q & ~tick);
            if (apply) begin
                active_q.thr  <= staged_q.thr;
                active_q.stop <= staged_q.stop;
                if (!busy) begin
                    active_q.en <= staged_q.en;
                end
            end
            if (seq_done) begin
                active_q.en <= 1'b0;
            end
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!apply && !seq_done) |=> $stable(active_q));  // R2

    AST_EN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !active_q.en);  // R9

endmodule

// File: rtl/bc_seq.sv
module bc_seq
    import bc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    start,
    input  bc_cfg_t cfg,
    input  logic    sda_in,
    output logic    scl_low,
    output logic    sda_low,
    output logic    busy,
    output logic    done,
    output logic    last_sda
);

    bc_state_t        st_q;
    logic [THR_W-1:0] cnt_q;
    logic [THR_W-1:0] lim_q;
    logic [THR_W-1:0] cnt_nxt;
    logic             stop_q;
    logic             sda_q;

    assign cnt_nxt  = cnt_q + 1'b1;
    assign scl_low  = (st_q == ST_LOW) || (st_q == ST_STOP_A);
    assign sda_low  = (st_q == ST_STOP_A) || (st_q == ST_STOP_B);
    assign busy     = (st_q != ST_IDLE);
    assign done     = (st_q == ST_END);
    assign last_sda = sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            lim_q  <= '0;
            stop_q <= 1'b0;
            sda_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_LOW;
                        cnt_q  <= '0;
                        lim_q  <= pulse_limit(cfg.thr);
                        stop_q <= cfg.stop;
                    end
                end
                ST_LOW: begin
                    if (tick) st_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tick) begin
                        sda_q <= sda_in;
                        cnt_q <= cnt_nxt;
                        if (sda_in || (cnt_nxt == lim_q)) begin
                            st_q <= stop_q ? ST_STOP_A : ST_END;
                        end else begin
                            st_q <= ST_LOW;
                        end
                    end
                end
                ST_STOP_A: begin
                    if (tick) st_q <= ST_STOP_B;
                end
                ST_STOP_B: begin
                    if (tick) st_q <= ST_END;
                end
                ST_END: begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOW && !tick) |=> (st_q == ST_LOW));  // R3

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= lim_q));  // R4

    AST_EARLY_END: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HIGH && tick && sda_in) |=> (st_q != ST_LOW));  // R5

    AST_SDA_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
        sda_low |-> stop_q);  // R6

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> (st_q == ST_IDLE));  // R9

endmodule

// File: rtl/bc_irq.sv
module bc_irq
    import bc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              last_sda,
    input  logic              int_wr,
    input  logic [WORD_W-1:0] int_wdata,
    output logic              irq,
    output logic              freed
);

    logic irq_q;
    logic freed_q;
    logic clr;

    assign clr   = int_wr & int_wdata[IRQ_POS];
    assign irq   = irq_q;
    assign freed = freed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            freed_q <= 1'b0;
        end else begin
            if (done) begin
                irq_q   <= 1'b1;
                freed_q <= last_sda;
            end else if (clr) begin
                irq_q <= 1'b0;
            end
        end
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr) |=> irq_q);  // R7

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        done |=> (irq_q && (freed_q == $past(last_sda))));  // R8

endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
    import bc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        load_req,
    input  logic        int_wr,
    input  logic [31:0] int_wdata,
    input  logic        sda_in,
    output logic        scl_low_o,
    output logic        sda_low_o,
    output logic        busy_o,
    output logic        load_pending_o,
    output logic [31:0] cfg_q_o,
    output logic        irq_done_o,
    output logic        sda_freed_o
);

    bc_cfg_t staged;
    bc_cfg_t active;
    logic    start;
    logic    busy;
    logic    done;
    logic    last_sda;

    bc_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .load_req  (load_req),
        .busy      (busy),
        .seq_done  (done),
        .staged    (staged),
        .active    (active),
        .pending   (load_pending_o),
        .start     (start)
    );

    bc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .start    (start),
        .cfg      (staged),
        .sda_in   (sda_in),
        .scl_low  (scl_low_o),
        .sda_low  (sda_low_o),
        .busy     (busy),
        .done     (done),
        .last_sda (last_sda)
    );

    bc_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .last_sda  (last_sda),
        .int_wr    (int_wr),
        .int_wdata (int_wdata),
        .irq       (irq_done_o),
        .freed     (sda_freed_o)
    );

    assign busy_o  = busy;
    assign cfg_q_o = cfg_pack(active);

    AST_SCL_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (scl_low_o || sda_low_o) |-> busy_o);  // R3

endmodule

// File: tb/i2c_bus_recover_tb.sv
module i2c_bus_recover_tb;

    typedef struct {
        int pulses;
        bit freed;
        bit stop;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        tick = 0;
    logic        cfg_wr = 0;
    logic [31:0] cfg_wdata = '0;
    logic        load_req = 0;
    logic        int_wr = 0;
    logic [31:0] int_wdata = '0;
    logic        sda_in;
    logic        scl_low_o, sda_low_o, busy_o, load_pending_o, irq_done_o, sda_freed_o;
    logic [31:0] cfg_q_o;

    int total = 0;
    int bad   = 0;
    exp_t q[$];

    int  rel_after = 0;
    int  rises = 0;
    bit  slave_clr = 0;
    logic prev_scl = 0;

    int  tcnt = 0;
    int  m_pulses = 0;
    int  m_width = 0;
    bit  m_stop = 0;
    logic m_prev_scl = 0;
    logic m_prev_irq = 0;
    int  irq_events = 0;

    i2c_bus_recover u_dut (.*);

    always #10 clk = ~clk;

    assign sda_in = (rises >= rel_after) && !sda_low_o;

    always @(negedge clk) begin
        tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
        tick <= (tcnt == 3);
    end

    always @(posedge clk) begin
        prev_scl <= scl_low_o;
        if (slave_clr) rises <= 0;
        else if (prev_scl && !scl_low_o) rises <= rises + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pulse widths, STOP detection, scoreboard pop on done
    always @(negedge clk) begin
        if (!rst) begin
            if (scl_low_o) m_width <= m_width + 1;
            if (scl_low_o && !m_prev_scl && !sda_low_o) m_pulses <= m_pulses + 1;
            if (!scl_low_o && m_prev_scl && !m_stop && !sda_low_o) begin
                check(m_width == 4, "R3 pulse width", m_width, 4);
                m_width <= 0;
            end
            if (!scl_low_o && m_prev_scl) m_width <= 0;
            if (sda_low_o && !scl_low_o) m_stop <= 1;
            if (irq_done_o && !m_prev_irq) begin
                irq_events++;
                if (q.size() == 0) begin
                    check(0, "R9 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(m_pulses == e.pulses, "R4/R5 pulse count", m_pulses, e.pulses);
                    check(sda_freed_o == e.freed, "R8 freed status", sda_freed_o, e.freed);
                    check(m_stop == e.stop, "R6 stop seen", m_stop, e.stop);
                end
                m_pulses <= 0;
                m_stop   <= 0;
            end
            m_prev_scl <= scl_low_o;
            m_prev_irq <= irq_done_o;
        end
    end

    task automatic write_cfg(input logic [31:0] w, input bit do_load);
        @(negedge clk);
        cfg_wr = 1; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 0;
        if (do_load) begin
            load_req = 1;
            @(negedge clk);
            load_req = 0;
        end
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!irq_done_o && n < 5000) begin @(negedge clk); n++; end
        check(irq_done_o == 1, "R7 done flag set", irq_done_o, 1);
    endtask

    task automatic clear_irq();
        @(negedge clk);
        int_wr = 1; int_wdata = 32'h0;
        @(negedge clk);
        int_wr = 0;
        @(negedge clk);
        check(irq_done_o == 1, "R7 write of 0 keeps flag", irq_done_o, 1);
        int_wr = 1; int_wdata = 32'h1 << 11;
        @(negedge clk);
        int_wr = 0;
        @(negedge clk);
        check(irq_done_o == 0, "R7 write-one clears flag", irq_done_o, 0);
    endtask

    task automatic run_case(input int thr, input bit stop, input int k);
        exp_t e;
        int lim, kk;
        lim = (thr == 0) ? 1 : thr;
        kk  = (k < 1) ? 1 : k;
        e.pulses = (kk < lim) ? kk : lim;
        e.freed  = (kk <= lim);
        e.stop   = stop;
        @(negedge clk);
        slave_clr = 1; rel_after = k;
        @(negedge clk);
        slave_clr = 0;
        q.push_back(e);
        write_cfg((32'(thr) << 16) | (32'(stop) << 1) | 32'h1, 1);
        check(load_pending_o == 1, "R2 load pending", load_pending_o, 1);
        while (load_pending_o) @(negedge clk);
        check(cfg_q_o == ((32'(thr) << 16) | (32'(stop) << 1) | 32'h1), "R2 fields loaded",
              cfg_q_o, (thr << 16) | (stop << 1) | 1);
        wait_irq();
        @(negedge clk);
        check(cfg_q_o[0] == 0, "R9 enable self-clears", cfg_q_o[0], 0);
        check(sda_low_o == 0 && scl_low_o == 0, "R6 lines released", sda_low_o, 0);
        clear_irq();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(scl_low_o == 0 && sda_low_o == 0, "R1 lines idle", scl_low_o, 0);
        check(busy_o == 0 && load_pending_o == 0, "R1 busy/pending", busy_o, 0);
        check(irq_done_o == 0 && sda_freed_o == 0, "R1 flags", irq_done_o, 0);
        check(cfg_q_o == 0, "R1 cfg", cfg_q_o, 0);

        // staging write alone has no effect
        write_cfg(32'h0009_0003, 0);
        repeat (40) @(negedge clk);
        check(busy_o == 0 && scl_low_o == 0, "R2 no start without load", busy_o, 0);
        check(cfg_q_o == 0, "R2 cfg unchanged without load", cfg_q_o, 0);

        run_case(9, 0, 3);    // early release, R5
        run_case(9, 0, 20);   // full threshold, still stuck, R4
        run_case(9, 1, 4);    // STOP appended, R6
        run_case(0, 0, 5);    // threshold 0 acts as 1, R4
        run_case(5, 1, 0);    // already free, one pulse, R5
        run_case(3, 1, 3);    // release on last pulse

        // R9: reload with enable while running is ignored
        begin
            exp_t e;
            @(negedge clk);
            slave_clr = 1; rel_after = 100;
            @(negedge clk);
            slave_clr = 0;
            e.pulses = 9; e.freed = 0; e.stop = 0;
            q.push_back(e);
            irq_events = 0;
            write_cfg(32'h0009_0001, 1);
            repeat (20) @(negedge clk);
            check(busy_o == 1, "R9 running", busy_o, 1);
            write_cfg(32'h0002_0001, 1);
            while (load_pending_o) @(negedge clk);
            check(cfg_q_o[0] == 1, "R9 enable stays set while running", cfg_q_o[0], 1);
            wait_irq();
            repeat (100) @(negedge clk);
            check(busy_o == 0, "R9 no restart", busy_o, 0);
            check(irq_events == 1, "R9 single completion", irq_events, 1);
            check(cfg_q_o[0] == 0, "R9 enable cleared", cfg_q_o[0], 0);
            clear_irq();
        end

        check(q.size() == 0, "R7 all completions seen", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule